// File: doc/BRIEF.md
# Logic Analyzer Trigger Unit

This block decides when a logic analyzer capture has found its trigger. Each time the sample enable is high it takes one word from a 16-bit sampled bus. Every channel can be ignored, compared against a level, or watched for a rising or falling edge. The AND of all channel results is the internal condition, and that condition can be inverted. An external trigger pin, compared against a programmed level, can replace the internal condition.

The selected condition must stay true for a minimum number of consecutive samples before it counts as one hit. Each unbroken run of true samples gives at most one hit. Once enough hits have been counted, a sticky trigger flag is raised. The flag stays high until the next arm/clear command.

Top module: `trig_unit`

## Requirements
- R1: A channel whose mask bit is 0 has no effect on the internal condition. With the whole mask at zero, every enabled sample satisfies the uninverted condition.
- R2: A masked-in channel with edge bit 0 matches when its sample bit equals its value bit.
- R3: A masked-in channel with edge bit 1 matches on a change from the previous enabled sample. Value bit 1 selects a rising edge (0 to 1) and value bit 0 selects a falling edge (1 to 0). The first enabled sample after a clear or reset never matches an edge.
- R4: A hit is counted on the enabled sample where the condition has been true for `lenCode` consecutive enabled samples, with code 0 treated as 1. One unbroken run gives at most one hit.
- R5: `trigFlag` rises on the clock edge that registers the hit which brings the hit count to `hitCode`, with code 0 treated as 1. It is visible after that edge.
- R6: With `invert` at 1 and `extSel` at 0, the condition is the negation of the masked comparison.
- R7: With `extSel` at 1, the condition is `extTrig == extLevel`, and the sample bus is ignored. Length and hit-count qualification still apply.
- R8: Once set, `trigFlag` stays at 1 whatever the inputs, until `armClr` or reset.
- R9: Reset, or a clock edge with `armClr` high, clears the flag, the run and hit counters and the stored previous sample. `armClr` takes priority over a coincident `sampleEn`, and that sample is discarded.
- R10: Clock edges with `sampleEn` low change nothing. A run of true samples separated by disabled cycles is still one unbroken run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armClr | input | 1 | Synchronous clear / arm command |
| sampleEn | input | 1 | One sample taken on each clock edge where this is high |
| sampleData | input | 16 | Sampled input bus |
| trigValue | input | 16 | Per-channel level, or edge direction |
| trigMask | input | 16 | Per-channel compare enable (1 = compared) |
| trigEdge | input | 16 | Per-channel edge select (1 = edge, 0 = level) |
| lenCode | input | 4 | Minimum run length in samples (0 acts as 1) |
| hitCode | input | 4 | Hits needed to trigger (0 acts as 1) |
| invert | input | 1 | Negate the internal comparison |
| extSel | input | 1 | Use the external pin instead of the bus |
| extLevel | input | 1 | Level the external pin is compared to |
| extTrig | input | 1 | External trigger pin |
| trigFlag | output | 1 | Sticky trigger flag |

## Verification
A clear command and a sample that would qualify as the final hit can arrive on the same clock edge. The bench provokes this by raising `armClr` and `sampleEn` together while the bus holds a matching word, and requires the flag to read 0 afterwards. It also requires the next sample to be treated as the first after a clear, so it cannot produce an edge. A behavioural reference model, kept as plain integers, is compared with `trigFlag` on every clock. It covers long randomized stretches in which clears, disabled cycles and qualifying samples fall together.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic clear;
    logic step;
  } trigStrb_t;

  function automatic logic [CODE_W:0] effCount(input logic [CODE_W-1:0] code);
    return (code == '0) ? (CODE_W+1)'(1) : {1'b0, code};
  endfunction
endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  trigStrb_t         strb,
  input  logic [WIDTH-1:0]  sampleData,
  input  logic [WIDTH-1:0]  trigValue,
  input  logic [WIDTH-1:0]  trigMask,
  input  logic [WIDTH-1:0]  trigEdge,
  input  logic [CODE_W-1:0] lenCode,
  input  logic              invert,
  input  logic              extSel,
  input  logic              extLevel,
  input  logic              extTrig,
  output logic              hitNow,
  output logic [CODE_W:0]   hitCnt
);
  localparam int CNT_W = CODE_W + 1;

  logic [WIDTH-1:0] prevData;
  logic             prevValid;
  logic [WIDTH-1:0] chanOk;
  logic             intMatch;
  logic             cond;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] lenEff;

  // per-channel compare: ignored, level, or edge against previous sample
  for (genvar b = 0; b < WIDTH; b++) begin : g_chan
    assign chanOk[b] = !trigMask[b] ||
                       (trigEdge[b] ? (prevValid && (prevData[b] != trigValue[b]) &&
                                       (sampleData[b] == trigValue[b]))
                                    : (sampleData[b] == trigValue[b]));
  end

  assign intMatch = (&chanOk) ^ invert;
  assign cond     = extSel ? (extTrig == extLevel) : intMatch;
  assign lenEff   = effCount(lenCode);
  assign hitNow   = strb.step && cond && (runCnt == lenEff - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevData  <= '0;
      prevValid <= 1'b0;
      runCnt    <= '0;
      hitCnt    <= '0;
    end else if (strb.clear) begin
      prevData  <= '0;
      prevValid <= 1'b0;
      runCnt    <= '0;
      hitCnt    <= '0;
    end else if (strb.step) begin
      prevData  <= sampleData;
      prevValid <= 1'b1;
      if (!cond)                runCnt <= '0;
      else if (runCnt < lenEff) runCnt <= runCnt + 1'b1;
      if (hitNow && (hitCnt != '1)) hitCnt <= hitCnt + 1'b1;
    end
  end

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (hitCnt == '0 && runCnt == '0 && !prevValid));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.clear) |=> ($stable(hitCnt) && $stable(runCnt) && $stable(prevData)));

  p_one_hit_per_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    hitNow |=> (!hitNow || lenCode != $past(lenCode)));

  p_hit_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> (hitCnt == $past(hitCnt) || hitCnt == $past(hitCnt) + 1'b1));
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              armClr,
  input  logic              sampleEn,
  input  logic              hitNow,
  input  logic [CODE_W:0]   hitCnt,
  input  logic [CODE_W-1:0] hitCode,
  output trigStrb_t         strb,
  output logic              trigFlag
);
  logic [CODE_W+1:0] countAfter;
  logic [CODE_W:0]   hitEff;

  assign strb.clear = armClr;
  assign strb.step  = sampleEn && !armClr;
  assign hitEff     = effCount(hitCode);
  assign countAfter = {1'b0, hitCnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   trigFlag <= 1'b0;
    else if (armClr)                             trigFlag <= 1'b0;
    else if (hitNow && countAfter >= {1'b0, hitEff}) trigFlag <= 1'b1;
  end

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (trigFlag && !armClr) |=> trigFlag);

  p_rise_on_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigFlag) |-> $past(hitNow));

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    armClr |=> !trigFlag);
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armClr,
  input  logic              sampleEn,
  input  logic [WIDTH-1:0]  sampleData,
  input  logic [WIDTH-1:0]  trigValue,
  input  logic [WIDTH-1:0]  trigMask,
  input  logic [WIDTH-1:0]  trigEdge,
  input  logic [CODE_W-1:0] lenCode,
  input  logic [CODE_W-1:0] hitCode,
  input  logic              invert,
  input  logic              extSel,
  input  logic              extLevel,
  input  logic              extTrig,
  output logic              trigFlag
);
  trigStrb_t       strb;
  logic            hitNow;
  logic [CODE_W:0] hitCnt;

  trig_control i_ctrl (
    .clk(clk), .rstN(rstN), .armClr(armClr), .sampleEn(sampleEn),
    .hitNow(hitNow), .hitCnt(hitCnt), .hitCode(hitCode),
    .strb(strb), .trigFlag(trigFlag)
  );

  trig_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleData(sampleData),
    .trigValue(trigValue), .trigMask(trigMask), .trigEdge(trigEdge),
    .lenCode(lenCode), .invert(invert), .extSel(extSel),
    .extLevel(extLevel), .extTrig(extTrig), .hitNow(hitNow), .hitCnt(hitCnt)
  );
endmodule

// File: tb/test_trig_unit.sv
module test_trig_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armClr = 1'b0, sampleEn = 1'b0;
  logic [15:0] sampleData = '0, trigValue = '0, trigMask = '0, trigEdge = '0;
  logic [3:0]  lenCode = 4'd1, hitCode = 4'd1;
  logic        invert = 1'b0, extSel = 1'b0, extLevel = 1'b0, extTrig = 1'b0;
  logic        trigFlag;

  int    checks = 0, errors = 0;
  bit    checkOn = 1'b0, finished = 1'b0;
  string curReq = "R9";

  // behavioural reference state
  logic [15:0] mPrev;
  bit          mPv, mFlag;
  int          mRun, mHits;

  trig_unit i_trig_unit (
    .clk(clk), .rstN(rstN), .armClr(armClr), .sampleEn(sampleEn),
    .sampleData(sampleData), .trigValue(trigValue), .trigMask(trigMask),
    .trigEdge(trigEdge), .lenCode(lenCode), .hitCode(hitCode),
    .invert(invert), .extSel(extSel), .extLevel(extLevel),
    .extTrig(extTrig), .trigFlag(trigFlag)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN || armClr) begin
      mPrev = '0; mPv = 0; mRun = 0; mHits = 0; mFlag = 0;
    end else if (sampleEn) begin
      bit ok, c;
      int k, j;
      ok = 1;
      for (int i = 0; i < 16; i++) begin
        if (trigMask[i]) begin
          if (trigEdge[i]) begin
            if (trigValue[i] && !(mPv && !mPrev[i] && sampleData[i])) ok = 0;
            if (!trigValue[i] && !(mPv && mPrev[i] && !sampleData[i])) ok = 0;
          end else if (sampleData[i] != trigValue[i]) ok = 0;
        end
      end
      c = extSel ? (extTrig == extLevel) : (invert ? !ok : ok);
      k = (lenCode == 0) ? 1 : int'(lenCode);
      j = (hitCode == 0) ? 1 : int'(hitCode);
      if (c) begin
        mRun++;
        if (mRun == k) begin
          mHits++;
          if (mHits >= j) mFlag = 1;
        end
      end else mRun = 0;
      mPrev = sampleData; mPv = 1;
    end
  end

  always @(negedge clk) begin
    if (checkOn && !finished) begin
      checks++;
      if (trigFlag !== mFlag) begin
        errors++;
        $display("FAIL %s (model compare): trigFlag=%0d expected %0d", curReq, trigFlag, mFlag);
      end
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doClear();
    armClr = 1; sampleEn = 0; step(); armClr = 0;
  endtask

  task automatic smp(input logic [15:0] d);
    sampleEn = 1; sampleData = d; step(); sampleEn = 0;
  endtask

  task automatic expectFlag(input bit exp, input string req);
    checks++;
    if (trigFlag !== exp) begin
      errors++;
      $display("FAIL %s: trigFlag=%0d expected %0d", req, trigFlag, exp);
    end
  endtask

  task automatic setLevel(input logic [15:0] v, input logic [15:0] m);
    trigValue = v; trigMask = m; trigEdge = '0; invert = 0; extSel = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    expectFlag(0, "R9 reset state");
    checkOn = 1;

    // R2 level compare
    curReq = "R2";
    setLevel(16'hA5A5, 16'hFFFF); lenCode = 1; hitCode = 1;
    smp(16'h0000); expectFlag(0, "R2 mismatch");
    smp(16'hA5A4); expectFlag(0, "R2 one bit off");
    smp(16'hA5A5); expectFlag(1, "R2 match");

    // R1 masking
    curReq = "R1"; doClear();
    setLevel(16'h0033, 16'h00FF);
    smp(16'hFF33); expectFlag(1, "R1 upper byte ignored");
    doClear(); setLevel(16'h1234, 16'h0000);
    smp(16'hBEEF); expectFlag(1, "R1 empty mask");

    // R3 edges
    curReq = "R3"; doClear();
    setLevel(16'h0001, 16'h0001); trigEdge = 16'h0001;
    smp(16'h0001); expectFlag(0, "R3 first sample no edge");
    smp(16'h0000); expectFlag(0, "R3 low");
    smp(16'h0001); expectFlag(1, "R3 rising");
    doClear(); trigValue = 16'h0000;
    smp(16'h0001); smp(16'h0001); expectFlag(0, "R3 no change");
    smp(16'h0000); expectFlag(1, "R3 falling");

    // R4 length qualification
    curReq = "R4"; doClear();
    setLevel(16'h00F0, 16'hFFFF); lenCode = 3; hitCode = 1;
    smp(16'h00F0); smp(16'h00F0); smp(16'h0000);
    smp(16'h00F0); smp(16'h00F0); expectFlag(0, "R4 runs of two");
    smp(16'h00F0); expectFlag(1, "R4 third consecutive");
    doClear(); lenCode = 0;
    smp(16'h00F0); expectFlag(1, "R4 code zero acts as one");

    // R5 hit count, one hit per run
    curReq = "R5"; doClear(); lenCode = 2; hitCode = 3;
    repeat (5) smp(16'h00F0);
    smp(16'h0000); expectFlag(0, "R5 long run one hit");
    smp(16'h00F0); smp(16'h00F0); smp(16'h0000); expectFlag(0, "R5 two hits");
    smp(16'h00F0); expectFlag(0, "R5 before third");
    smp(16'h00F0); expectFlag(1, "R5 third hit");
    doClear(); lenCode = 1; hitCode = 0;
    smp(16'h00F0); expectFlag(1, "R5 code zero acts as one");

    // R6 invert
    curReq = "R6"; doClear(); hitCode = 1;
    setLevel(16'h1234, 16'hFFFF); invert = 1;
    smp(16'h1234); expectFlag(0, "R6 equal gives false");
    smp(16'h0000); expectFlag(1, "R6 unequal gives true");

    // R7 external
    curReq = "R7"; doClear(); invert = 0;
    extSel = 1; extLevel = 1; lenCode = 2; extTrig = 0;
    smp(16'h1234); smp(16'h1234); expectFlag(0, "R7 bus ignored");
    extTrig = 1; smp(16'h0000); expectFlag(0, "R7 length one of two");
    smp(16'h0000); expectFlag(1, "R7 external qualified");

    // R8 sticky
    curReq = "R8"; extTrig = 0;
    repeat (6) smp(16'h0000);
    step(); expectFlag(1, "R8 stays set");

    // R9 clear together with qualifying sample
    curReq = "R9"; extSel = 0; setLevel(16'h0001, 16'h0001); trigEdge = 16'h0001;
    lenCode = 1; hitCode = 1;
    armClr = 1; sampleEn = 1; sampleData = 16'h0000; step();
    armClr = 0; sampleEn = 0;
    expectFlag(0, "R9 clear wins");
    smp(16'h0001); expectFlag(0, "R9 coincident sample discarded");
    setLevel(16'h5555, 16'hFFFF);
    armClr = 1; sampleEn = 1; sampleData = 16'h5555; step();
    armClr = 0; sampleEn = 0;
    expectFlag(0, "R9 clear over level match");

    // R10 disabled cycles
    curReq = "R10"; doClear(); lenCode = 2;
    sampleData = 16'h5555; repeat (4) step();
    expectFlag(0, "R10 no enable no hit");
    smp(16'h5555);
    sampleData = 16'h0000; repeat (3) step();
    smp(16'h5555); expectFlag(1, "R10 gap keeps run");

    // randomized mix, compared to the model every clock
    curReq = "R1 R2 R3 R4 R5 R6 R7 mix";
    for (int blk = 0; blk < 60; blk++) begin
      doClear();
      trigMask  = 16'($urandom % 16);
      trigValue = 16'($urandom % 16);
      trigEdge  = 16'($urandom % 16) & trigMask;
      lenCode   = 4'($urandom % 4);
      hitCode   = 4'($urandom % 4);
      invert    = 1'($urandom % 2);
      extSel    = ($urandom % 5) == 0;
      extLevel  = 1'($urandom % 2);
      for (int c = 0; c < 40; c++) begin
        sampleEn   = ($urandom % 4) != 0;
        armClr     = ($urandom % 50) == 0;
        sampleData = 16'($urandom % 16);
        extTrig    = 1'($urandom % 2);
        step();
      end
      armClr = 0; sampleEn = 0;
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule